// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block turns one input clock into two families of divided clocks. Family A runs at one half or one quarter of the input rate. Family B runs at one quarter or one sixth of the input rate. A static select pin sets the ratio of each family. Every divider register sits on the rising edge of the same input clock. As a result, any rising edge that the two families share happens on the same input edge. Every divided output has a 50% duty cycle.

A single shared frame counter paces both families. Its length is the least common multiple of all the ratios, which is 12 input cycles by default. The enable pin is sampled on the falling edge of the input clock. When the enable is sampled high while the block is idle, all outputs start a fresh period together on the next rising edge. When the enable is sampled low, the outputs keep running until the end of the current frame, where every output is already low, and then stay low. This means no output pulse is ever shortened.

An asynchronous master reset clears every divider, the frame counter and the sampled enable. Several instances released from the same reset therefore start in the same phase. The divided clocks carry no data, so there is no valid/ready interface here; all pins are plain control and clock signals.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: With sel_a = 0, each family-A output repeats every 2 input cycles: high for 1, then low for 1. With sel_a = 1 the period is 4 cycles: high for 2, then low for 2.
- R2: With sel_b = 0, each family-B output repeats every 4 input cycles: high for 2, then low for 2. With sel_b = 1 the period is 6 cycles: high for 3, then low for 3.
- R3: The copies of a family are equal on every cycle.
- R4: The enable is captured on the falling edge of the input clock. If it is captured high while the block is idle, all outputs go high on the next rising edge. That edge is counted as cycle k = 0 of the run.
- R5: Every output begins its first period on the same input edge. In cycle k of a run, an output of ratio N is high exactly when (k mod N) < N/2.
- R6: Once the enable is captured low, outputs continue unchanged until the end of the current 12-cycle frame. They are then held low, so a run that is stopped at k = 5 shows its normal pattern through k = 11 and is low from k = 12 on.
- R7: If the enable drops and returns high before the end of the frame, it has no effect on any output.
- R8: Asserting the master reset forces every output low at once, without waiting for a clock edge. The sampled enable is also cleared.
- R9: After reset is released, all outputs stay low for as long as the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock that drives every divider |
| mreset | input | 1 | Asynchronous master reset, active high |
| en | input | 1 | Output enable, sampled on the falling clock edge |
| sel_a | input | 1 | Family A ratio: 0 selects /2, 1 selects /4 |
| sel_b | input | 1 | Family B ratio: 0 selects /4, 1 selects /6 |
| out_a | output | COPIES (2) | Family A divided clocks |
| out_b | output | COPIES (2) | Family B divided clocks |

## Verification
The assertions treat sel_a and sel_b as fixed during a run. A ratio change is only guaranteed to take effect cleanly across a master reset. The bench therefore changes the selects only while mreset is held. The single-cycle-high check on family A relies on the default low ratio of 2. The enable, by contrast, may change in any cycle, and the bench deliberately toggles it both just after a rising edge and just after a falling edge.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;

  // Control strobes issued by the frame sequencer to every path divider.
  typedef struct packed {
    logic start;  // begin a fresh period from phase zero, outputs high
    logic step;   // advance one input cycle
    logic halt;   // stop at a frame boundary, outputs low
  } seq_ctrl_t;

  function automatic int gcd_of(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm_of(input int a, input int b);
    return (a / gcd_of(a, b)) * b;
  endfunction

endpackage

// File: rtl/enable_sampler.sv
module enable_sampler (
  input  logic clk_in,
  input  logic mreset,
  input  logic en,
  output logic en_s
);
  // Falling-edge capture: the result is stable across the low half and
  // reaches the rising-edge logic half a cycle later.
  always_ff @(negedge clk_in or posedge mreset) begin
    if (mreset) en_s <= 1'b0;
    else        en_s <= en;
  end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import dual_div_pkg::*;
#(
  parameter int FRAME_LEN = 12
) (
  input  logic      clk_in,
  input  logic      mreset,
  input  logic      en_s,
  output seq_ctrl_t ctrl,
  output logic      running
);
  localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] cnt;
  logic          at_end;

  always_comb begin
    at_end     = running && (cnt == LAST);
    ctrl.start = !running && en_s;
    ctrl.halt  = at_end && !en_s;
    ctrl.step  = running && !ctrl.halt;
  end

  always_ff @(posedge clk_in or posedge mreset) begin
    if (mreset) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      if (ctrl.start || ctrl.halt) cnt <= '0;
      else if (ctrl.step)          cnt <= at_end ? '0 : cnt + CW'(1);
      if (ctrl.start)      running <= 1'b1;
      else if (ctrl.halt)  running <= 1'b0;
    end
  end
endmodule

// File: rtl/path_divider.sv
module path_divider
  import dual_div_pkg::*;
#(
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 4,
  parameter int COPIES = 2
) (
  input  logic              clk_in,
  input  logic              mreset,
  input  logic              sel,
  input  seq_ctrl_t         ctrl,
  output logic [COPIES-1:0] clk_out
);
  localparam int MAXD = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int PW   = $clog2(MAXD + 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] phase_nxt;
  logic [PW-1:0] lim;
  logic [PW-1:0] half;
  logic          level_nxt;

  always_comb begin
    lim       = sel ? PW'(DIV_HI) : PW'(DIV_LO);
    half      = lim >> 1;
    phase_nxt = (phase == lim - PW'(1)) ? '0 : phase + PW'(1);
    level_nxt = phase_nxt < half;
  end

  always_ff @(posedge clk_in or posedge mreset) begin
    if (mreset)                      phase <= '0;
    else if (ctrl.start || ctrl.halt) phase <= '0;
    else if (ctrl.step)              phase <= phase_nxt;
  end

  // One register per copy, each fed from the shared phase decode.
  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    always_ff @(posedge clk_in or posedge mreset) begin
      if (mreset)          clk_out[g] <= 1'b0;
      else if (ctrl.start) clk_out[g] <= 1'b1;
      else if (ctrl.halt)  clk_out[g] <= 1'b0;
      else if (ctrl.step)  clk_out[g] <= level_nxt;
    end
  end
endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
  import dual_div_pkg::*;
#(
  parameter int A_LO   = 2,
  parameter int A_HI   = 4,
  parameter int B_LO   = 4,
  parameter int B_HI   = 6,
  parameter int COPIES = 2
) (
  input  logic              clk_in,
  input  logic              mreset,
  input  logic              en,
  input  logic              sel_a,
  input  logic              sel_b,
  output logic [COPIES-1:0] out_a,
  output logic [COPIES-1:0] out_b
);
  localparam int FRAME_LEN = lcm_of(lcm_of(A_LO, A_HI), lcm_of(B_LO, B_HI));

  logic      en_s;
  logic      running;
  seq_ctrl_t ctrl;

  enable_sampler u_en (
    .clk_in (clk_in),
    .mreset (mreset),
    .en     (en),
    .en_s   (en_s)
  );

  frame_sequencer #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk_in  (clk_in),
    .mreset  (mreset),
    .en_s    (en_s),
    .ctrl    (ctrl),
    .running (running)
  );

  path_divider #(.DIV_LO(A_LO), .DIV_HI(A_HI), .COPIES(COPIES)) u_path_a (
    .clk_in  (clk_in),
    .mreset  (mreset),
    .sel     (sel_a),
    .ctrl    (ctrl),
    .clk_out (out_a)
  );

  path_divider #(.DIV_LO(B_LO), .DIV_HI(B_HI), .COPIES(COPIES)) u_path_b (
    .clk_in  (clk_in),
    .mreset  (mreset),
    .sel     (sel_b),
    .ctrl    (ctrl),
    .clk_out (out_b)
  );
endmodule

// File: rtl/dual_ratio_clkdiv_chk.sv
module dual_ratio_clkdiv_chk #(
  parameter int COPIES = 2
) (
  input logic              clk_in,
  input logic              mreset,
  input logic              sel_a,
  input logic              sel_b,
  input logic              running,
  input logic [COPIES-1:0] out_a,
  input logic [COPIES-1:0] out_b
);
  // R3: all copies of a family match
  a_r3_copies_match: assert property (@(posedge clk_in) disable iff (mreset)
    (out_a == {COPIES{out_a[0]}}) && (out_b == {COPIES{out_b[0]}}));

  // R1: the /2 ratio is high for exactly one cycle
  a_r1_half_rate_pulse: assert property (@(posedge clk_in) disable iff (mreset)
    ($rose(out_a[0]) && !sel_a) |=> !out_a[0]);

  // R1: the /4 ratio never gives a single-cycle high
  a_r1_quarter_no_runt: assert property (@(posedge clk_in) disable iff (mreset)
    ($rose(out_a[0]) && sel_a) |=> out_a[0]);

  // R2: family B highs last at least two cycles
  a_r2_no_runt: assert property (@(posedge clk_in) disable iff (mreset)
    $rose(out_b[0]) |=> out_b[0]);

  // R2: the /6 ratio stays high for three cycles, then goes low
  a_r2_sixth_duty: assert property (@(posedge clk_in) disable iff (mreset)
    ($rose(out_b[0]) && sel_b) |=> out_b[0] ##1 out_b[0] ##1 !out_b[0]);

  // R6: nothing toggles while the sequencer is idle
  a_r6_idle_low: assert property (@(posedge clk_in) disable iff (mreset)
    !running |-> (out_a == '0 && out_b == '0));

  // R8: outputs are low whenever reset is seen at a clock edge
  a_r8_reset_quiet: assert property (@(posedge clk_in)
    mreset |-> (out_a == '0 && out_b == '0));
endmodule

bind dual_ratio_clkdiv dual_ratio_clkdiv_chk #(.COPIES(COPIES)) u_chk (
  .clk_in  (clk_in),
  .mreset  (mreset),
  .sel_a   (sel_a),
  .sel_b   (sel_b),
  .running (running),
  .out_a   (out_a),
  .out_b   (out_b)
);

// File: tb/dual_ratio_clkdiv_test.sv
module dual_ratio_clkdiv_test;
  logic       clk_in = 1'b0;
  logic       mreset = 1'b1;
  logic       en     = 1'b0;
  logic       sel_a  = 1'b0;
  logic       sel_b  = 1'b0;
  logic [1:0] out_a;
  logic [1:0] out_b;
  int         n_run  = 0;
  int         n_fail = 0;

  dual_ratio_clkdiv uut (
    .clk_in (clk_in),
    .mreset (mreset),
    .en     (en),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .out_a  (out_a),
    .out_b  (out_b)
  );

  always #5 clk_in = ~clk_in;  // 100 MHz

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic lvl(input int k, input int n);
    return (k % n) < (n / 2);
  endfunction

  function automatic logic [3:0] pattern(input int k, input logic sa, input logic sb);
    logic a;
    logic b;
    a = lvl(k, sa ? 4 : 2);
    b = lvl(k, sb ? 6 : 4);
    return {a, a, b, b};
  endfunction

  // two nanoseconds after a rising edge
  task automatic tick();
    @(posedge clk_in);
    #2;
  endtask

  task automatic hard_reset(input logic sa, input logic sb);
    en     = 1'b0;
    mreset = 1'b1;
    sel_a  = sa;
    sel_b  = sb;
    tick();
    mreset = 1'b0;
    tick();
  endtask

  task automatic t_reset_state();
    mreset = 1'b1;
    en     = 1'b0;
    #3;
    chk("R8 reset held", {out_a, out_b}, 4'b0000);
    tick();
    mreset = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R9 idle after reset", {out_a, out_b}, 4'b0000);
    end
  endtask

  task automatic t_ratio(input logic sa, input logic sb);
    hard_reset(sa, sb);
    en = 1'b1;  // captured at the coming falling edge
    for (int k = 0; k < 24; k++) begin
      tick();
      if (k == 0) chk("R4 R5 aligned start", {out_a, out_b}, 4'b1111);
      chk("R1 family A", {out_a, 2'b00}, {pattern(k, sa, sb)[3:2], 2'b00});
      chk("R2 family B", {2'b00, out_b}, {2'b00, pattern(k, sa, sb)[1:0]});
      chk("R3 copies equal", {1'b0, out_a[0] ^ out_a[1], 1'b0, out_b[0] ^ out_b[1]}, 4'b0000);
    end
  endtask

  task automatic t_late_enable();
    hard_reset(1'b1, 1'b1);
    @(posedge clk_in);
    #7;          // past the falling edge
    en = 1'b1;
    @(posedge clk_in);
    #2;
    chk("R4 not yet captured", {out_a, out_b}, 4'b0000);
    tick();
    chk("R4 start after falling-edge capture", {out_a, out_b}, 4'b1111);
  endtask

  task automatic t_disable();
    hard_reset(1'b1, 1'b1);
    en = 1'b1;
    for (int k = 0; k < 31; k++) begin
      tick();
      chk("R6 stop at frame end", {out_a, out_b}, (k < 12) ? pattern(k, 1'b1, 1'b1) : 4'b0000);
      if (k == 5) en = 1'b0;
    end
    en = 1'b1;
    tick();
    chk("R6 restart from idle", {out_a, out_b}, 4'b1111);
  endtask

  task automatic t_brief_drop();
    hard_reset(1'b0, 1'b1);
    en = 1'b1;
    for (int k = 0; k < 24; k++) begin
      tick();
      chk("R7 brief drop ignored", {out_a, out_b}, pattern(k, 1'b0, 1'b1));
      if (k == 5) en = 1'b0;
      if (k == 8) en = 1'b1;
    end
  endtask

  task automatic t_async_reset();
    hard_reset(1'b1, 1'b0);
    en = 1'b1;
    for (int k = 0; k < 4; k++) tick();  // k = 3, outputs high for /4 is k%4<2: low here
    tick();                              // k = 4: all high
    chk("R8 running before reset", {out_a, out_b}, 4'b1111);
    mreset = 1'b1;
    #1;
    chk("R8 immediate clear", {out_a, out_b}, 4'b0000);
    #1;
    mreset = 1'b0;   // enable still high, captured at the coming falling edge
    for (int k = 0; k < 12; k++) begin
      tick();
      chk("R5 realigned after reset", {out_a, out_b}, pattern(k, 1'b1, 1'b0));
    end
  endtask

  initial begin
    #3;
    t_reset_state();
    t_ratio(1'b0, 1'b0);
    t_ratio(1'b0, 1'b1);
    t_ratio(1'b1, 1'b0);
    t_ratio(1'b1, 1'b1);
    t_late_enable();
    t_disable();
    t_brief_drop();
    t_async_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule